// File: doc/BRIEF.md
# Page Buffer Write Controller

This block sits in front of a byte-wide nonvolatile array and turns a stream of host byte writes into whole-page programming operations. The host drives active-low chip enable, write enable and output enable with a 17-bit address and 8-bit data, all sampled on the system clock. Each accepted write cycle deposits one byte into a 128-byte page buffer. The buffer is indexed by the low seven address bits, and the upper ten bits name the page.

The load phase stays open for as long as new bytes keep arriving. When no byte has been loaded for a parameterised number of idle cycles, the controller commits the page. It raises a one-cycle strobe toward the array and presents the page address taken from the most recently loaded byte, together with a 128-byte image in which every byte the host never wrote reads as FFh. The controller stays busy for at least a parameterised programming time and until the array reports done. It ignores host writes during that time, then empties the buffer.

While a read is under way (chip enable and output enable low, write enable high), the data output shows the buffer byte at the addressed offset. An unloaded byte reads as FFh.

Top module: `pbw_page_writer`

## Requirements
- R1: A write cycle is recognised only while chip enable and write enable are both low and output enable is high; with output enable low nothing is loaded and no commit follows.
- R2: The address is captured in the first clock of a write cycle; address changes later in the same cycle do not move the byte.
- R3: The stored data is the value present in the last clock of the write cycle, before chip enable or write enable rises.
- R4: Address bits 6..0 select the buffer byte and bits 16..7 the page; a read (chip enable and output enable low, write enable high) returns the buffer byte at bits 6..0, FFh if unloaded, and the data output is 00h when no read is under way.
- R5: The commit strobe appears exactly TIMEOUT_CYCLES clocks after the clock in which the last byte was loaded; a new load before then restarts the count.
- R6: No commit occurs while a write cycle is open, however long it lasts; the idle count starts when it closes.
- R7: The commit strobe lasts one clock, busy is high in that clock, and the committed page address is bits 16..7 of the most recently loaded byte.
- R8: In the committed image each loaded byte holds its latest value (a repeated offset overwrites) and each unloaded byte is FFh.
- R9: Busy lasts at least PROG_CYCLES clocks and does not end before the array done input has been seen high.
- R10: Write cycles that start while busy is high load nothing.
- R11: When busy falls the buffer is empty: all reads return FFh and no commit follows without a new load.
- R12: After reset busy and the commit strobe are low and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | 17 | Byte address: page in 16..7, offset in 6..0 |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Buffer byte at the addressed offset during a read, else 00h |
| commitStb | output | 1 | One-clock strobe that starts array programming |
| commitPage | output | 10 | Page address to program |
| pageImage | output | 1024 | Page image, byte i at bits 8i+7..8i |
| arrDone | input | 1 | Array reports that programming is complete |
| busy | output | 1 | Programming in progress |

## Verification
Every cycle, the assertions check the following:
- the commit strobe is a single clock and coincides with busy;
- no commit follows a clock with an open write cycle;
- no byte is loaded while busy;
- busy never falls before the minimum programming count and the done handshake have both been reached;
- the controller is empty right after busy ends, and reads then return FFh.

Only the bench scenarios can show the rest. These are the exact idle count to the commit and its restart, the capture points of address and data within a cycle, the page chosen by the last byte, and the full 128-byte image with overwrites and FFh fill. The bench checks the image against an arithmetic model across a complete page sweep.

// File: rtl/pbw_pkg.sv
package pbw_pkg;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic latchAddr;   // first clock of an accepted write cycle
    logic sampleData;  // write cycle open: track data
    logic loadByte;    // write cycle closed: store held byte
    logic commit;      // idle timeout reached: start programming
    logic clearAll;    // programming finished: empty the buffer
  } pbwStrobes_t;

  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_LOAD  = 2'd1,
    ST_PROG  = 2'd2
  } pbwState_t;

endpackage

// File: rtl/pbw_ctrl.sv
module pbw_ctrl
  import pbw_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 25000,
  parameter int PROG_CYCLES    = 625000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceN,
  input  logic        weN,
  input  logic        oeN,
  input  logic        arrDone,
  output pbwStrobes_t strb,
  output logic        busy,
  output logic        commitStb
);

  localparam int IDLE_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam int PROG_W = $clog2(PROG_CYCLES + 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(TIMEOUT_CYCLES - 1);
  localparam logic [PROG_W-1:0] PROG_LAST = PROG_W'(PROG_CYCLES - 1);

  pbwState_t         stQ;
  logic              actQ, cycleOkQ, doneSeenQ, commitQ;
  logic [IDLE_W-1:0] idleCntQ;
  logic [PROG_W-1:0] progCntQ;
  logic              wrAct, wrRise, wrFall, progDone;

  assign wrAct  = ~ceN & ~weN & oeN;
  assign wrRise = wrAct & ~actQ;
  assign wrFall = ~wrAct & actQ;

  always_comb begin
    strb            = '0;
    strb.latchAddr  = wrRise & (stQ != ST_PROG);
    strb.sampleData = wrAct & (cycleOkQ | strb.latchAddr);
    strb.loadByte   = wrFall & cycleOkQ;
    strb.commit     = (stQ == ST_LOAD) & ~cycleOkQ & ~wrAct & (idleCntQ == IDLE_LAST);
    progDone        = (progCntQ == PROG_LAST) & (doneSeenQ | arrDone);
    strb.clearAll   = (stQ == ST_PROG) & progDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ       <= ST_EMPTY;
      actQ      <= 1'b0;
      cycleOkQ  <= 1'b0;
      doneSeenQ <= 1'b0;
      commitQ   <= 1'b0;
      idleCntQ  <= '0;
      progCntQ  <= '0;
    end else begin
      actQ    <= wrAct;
      commitQ <= strb.commit;
      if (strb.latchAddr)  cycleOkQ <= 1'b1;
      else if (wrFall)     cycleOkQ <= 1'b0;
      unique case (stQ)
        ST_EMPTY: begin
          if (strb.loadByte) begin
            stQ      <= ST_LOAD;
            idleCntQ <= '0;
          end
        end
        ST_LOAD: begin
          if (strb.loadByte) begin
            idleCntQ <= '0;
          end else if (strb.commit) begin
            stQ       <= ST_PROG;
            progCntQ  <= '0;
            doneSeenQ <= 1'b0;
          end else if (!cycleOkQ && !wrAct && idleCntQ < IDLE_LAST) begin
            idleCntQ <= idleCntQ + 1'b1;
          end
        end
        ST_PROG: begin
          if (strb.clearAll) begin
            stQ <= ST_EMPTY;
          end else begin
            if (progCntQ < PROG_LAST) progCntQ <= progCntQ + 1'b1;
            if (arrDone)              doneSeenQ <= 1'b1;
          end
        end
        default: stQ <= ST_EMPTY;
      endcase
    end
  end

  assign busy      = (stQ == ST_PROG);
  assign commitStb = commitQ;

  // R7
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |=> !commitStb);

  // R7
  commit_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |-> busy);

  // R6
  commit_closed_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |-> !$past(wrAct));

  // R10
  busy_noload_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.loadByte);

  // R9
  busy_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(busy)) |-> ($past(progCntQ) == PROG_LAST && $past(doneSeenQ | arrDone)));

  // R11
  busy_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(busy)) |-> (stQ == ST_EMPTY));

endmodule

// File: rtl/pbw_dpath.sv
module pbw_dpath
  import pbw_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 128
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  pbwStrobes_t                  strb,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            dataIn,
  input  logic                         rdEn,
  output logic [DATA_W-1:0]            rdData,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] commitPage,
  output logic [PAGE_BYTES*DATA_W-1:0] pageImage
);

  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataHoldQ;
  logic [PAGE_W-1:0] pageQ;
  logic [DATA_W-1:0] imgArr [PAGE_BYTES];
  logic [OFF_W-1:0]  offQ;

  assign offQ = addrQ[OFF_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ     <= '0;
      dataHoldQ <= '0;
      pageQ     <= '0;
    end else begin
      if (strb.latchAddr)  addrQ     <= addr;
      if (strb.sampleData) dataHoldQ <= dataIn;
      if (strb.loadByte)   pageQ     <= addrQ[ADDR_W-1:OFF_W];
    end
  end

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_byte
    logic [DATA_W-1:0] byteQ;
    logic              flagQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        byteQ <= '0;
        flagQ <= 1'b0;
      end else if (strb.clearAll) begin
        flagQ <= 1'b0;
      end else if (strb.loadByte && offQ == OFF_W'(i)) begin
        byteQ <= dataHoldQ;
        flagQ <= 1'b1;
      end
    end
    assign imgArr[i] = flagQ ? byteQ : '1;
    assign pageImage[i*DATA_W +: DATA_W] = imgArr[i];
  end

  assign rdData     = rdEn ? imgArr[addr[OFF_W-1:0]] : '0;
  assign commitPage = pageQ;

  // R11
  cleared_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.clearAll) && rdEn) |-> (rdData == '1));

endmodule

// File: rtl/pbw_page_writer.sv
module pbw_page_writer
  import pbw_pkg::*;
#(
  parameter int ADDR_W         = 17,
  parameter int DATA_W         = 8,
  parameter int PAGE_BYTES     = 128,
  parameter int TIMEOUT_CYCLES = 25000,
  parameter int PROG_CYCLES    = 625000
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         ceN,
  input  logic                         weN,
  input  logic                         oeN,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            dataIn,
  output logic [DATA_W-1:0]            dataOut,
  output logic                         commitStb,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] commitPage,
  output logic [PAGE_BYTES*DATA_W-1:0] pageImage,
  input  logic                         arrDone,
  output logic                         busy
);

  pbwStrobes_t strb;
  logic        rdEn;

  assign rdEn = ~ceN & ~oeN & weN;

  pbw_ctrl #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .PROG_CYCLES   (PROG_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ceN      (ceN),
    .weN      (weN),
    .oeN      (oeN),
    .arrDone  (arrDone),
    .strb     (strb),
    .busy     (busy),
    .commitStb(commitStb)
  );

  pbw_dpath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .addr      (addr),
    .dataIn    (dataIn),
    .rdEn      (rdEn),
    .rdData    (dataOut),
    .commitPage(commitPage),
    .pageImage (pageImage)
  );

endmodule

// File: tb/sim_pbw_page_writer.sv
`timescale 1ns/1ps
module sim_pbw_page_writer;

  localparam int TMO  = 40;
  localparam int PROG = 20;
  localparam int NB   = 128;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1, arrDone = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  dataIn = '0;
  logic [7:0]  dataOut;
  logic        commitStb, busy;
  logic [9:0]  commitPage;
  logic [NB*8-1:0] pageImage;

  int nChecks = 0;
  int nFail = 0;
  logic [7:0] expB [NB];
  logic [9:0] expPage;

  always #4 clk = ~clk;

  pbw_page_writer #(.TIMEOUT_CYCLES(TMO), .PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .addr(addr),
    .dataIn(dataIn), .dataOut(dataOut), .commitStb(commitStb),
    .commitPage(commitPage), .pageImage(pageImage), .arrDone(arrDone), .busy(busy));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearModel();
    for (int i = 0; i < NB; i++) expB[i] = 8'hFF;
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; dataIn = d; ceN = 1'b0; weN = 1'b0;
    @(negedge clk);
    @(negedge clk); ceN = 1'b1; weN = 1'b1;
    @(negedge clk);
    if (!busy) begin expB[a[6:0]] = d; expPage = a[16:7]; end
  endtask

  // address and data both change in the second clock of the cycle
  task automatic wrMid(input logic [16:0] a1, input logic [7:0] d1,
                       input logic [16:0] a2, input logic [7:0] d2);
    @(negedge clk); addr = a1; dataIn = d1; ceN = 1'b0; weN = 1'b0;
    @(negedge clk); addr = a2; dataIn = d2;
    @(negedge clk); ceN = 1'b1; weN = 1'b1;
    @(negedge clk);
    expB[a1[6:0]] = d2; expPage = a1[16:7];
  endtask

  task automatic wrLong(input logic [16:0] a, input logic [7:0] d, input int n);
    @(negedge clk); addr = a; dataIn = d; ceN = 1'b0; weN = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!commitStb, "R6 no commit while cycle open", commitStb, 0);
    end
    ceN = 1'b1; weN = 1'b1;
    @(negedge clk);
    expB[a[6:0]] = d; expPage = a[16:7];
  endtask

  task automatic rd(input logic [16:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; ceN = 1'b0; oeN = 1'b0; weN = 1'b1;
    #1 v = dataOut;
    ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic waitCommit(output int cyc);
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!commitStb && cyc < 1000);
  endtask

  task automatic quietFor(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (commitStb) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic imageChk();
    for (int i = 0; i < NB; i++)
      chk(pageImage[i*8 +: 8] == expB[i], "R8 image byte", pageImage[i*8 +: 8], expB[i]);
    chk(commitPage == expPage, "R7 commit page from last byte", commitPage, expPage);
    chk(busy == 1'b1, "R7 busy with strobe", busy, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int cyc;
    int bcnt;
    clearModel();
    expPage = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(busy == 1'b0, "R12 busy after reset", busy, 0);
    chk(commitStb == 1'b0, "R12 strobe after reset", commitStb, 0);
    chk(dataOut == 8'h00, "R4 idle output 00", dataOut, 0);
    rd(17'h00005, v);
    chk(v == 8'hFF, "R12 empty buffer reads FF", v, 8'hFF);

    // R1: output enable low blocks the write
    @(negedge clk); addr = 17'h00003; dataIn = 8'hAA; ceN = 1'b0; weN = 1'b0; oeN = 1'b0;
    repeat (3) @(negedge clk);
    ceN = 1'b1; weN = 1'b1; oeN = 1'b1;
    quietFor(TMO + 5, "R1 no commit with oe low");
    rd(17'h00003, v);
    chk(v == 8'hFF, "R1 byte not loaded with oe low", v, 8'hFF);

    // full page sweep, last byte in another page
    for (int off = 0; off < NB - 1; off++)
      wr({10'd5, 7'(off)}, 8'(off * 37 + 11));
    wr({10'd9, 7'd127}, 8'(127 * 37 + 11));
    waitCommit(cyc);
    chk(cyc == TMO, "R5 commit delay after last load", cyc, TMO);
    imageChk();
    // R9 early done: busy lasts exactly PROG clocks
    arrDone = 1'b1;
    bcnt = 0;
    while (busy && bcnt < 1000) begin
      bcnt++;
      @(negedge clk);
      arrDone = 1'b0;
    end
    chk(bcnt == PROG, "R9 minimum busy length", bcnt, PROG);
    rd(17'h00A00, v);
    chk(v == 8'hFF, "R11 buffer empty after program", v, 8'hFF);
    clearModel();

    // R2 R3 R8 R4: capture points, overwrite, readback
    wr(17'h0010A, 8'h12);
    wrMid(17'h00114, 8'h34, 17'h0011E, 8'h56);
    wr(17'h0010A, 8'h99);
    rd(17'h0010A, v); chk(v == 8'h99, "R8 overwrite readback", v, 8'h99);
    rd(17'h00114, v); chk(v == 8'h56, "R2 R3 capture points", v, 8'h56);
    rd(17'h0011E, v); chk(v == 8'hFF, "R2 late address ignored", v, 8'hFF);
    rd(17'h1FF0B, v); chk(v == 8'hFF, "R4 unloaded offset reads FF", v, 8'hFF);
    // R5 restart of the idle count
    quietFor(TMO - 6, "R5 no early commit");
    wr(17'h00128, 8'h01);
    quietFor(TMO - 3, "R5 count restarted");
    wrLong(17'h00129, 8'h02, TMO + 5);
    waitCommit(cyc);
    chk(cyc == TMO, "R6 idle count starts at cycle end", cyc, TMO);
    imageChk();
    // R10 write during busy
    wr(17'h00132, 8'h77);
    repeat (PROG + 5) @(negedge clk);
    chk(busy == 1'b1, "R9 busy waits for done", busy, 1);
    arrDone = 1'b1;
    @(negedge clk);
    arrDone = 1'b0;
    chk(busy == 1'b0, "R9 busy ends after done", busy, 0);
    rd(17'h00132, v);
    chk(v == 8'hFF, "R10 write during busy ignored", v, 8'hFF);
    quietFor(TMO + 5, "R11 no commit after program");

    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule